// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block is a byte-wide control register file that sits behind a serial-port front end. The front end presents one access per cycle as an address, a write strobe, a read strobe and a data byte. Every writable control register is kept twice. Writes land in a staging copy. The logic downstream sees only the live copy, which changes only when software issues an explicit transfer command. The command copies all staging registers into their live registers in the same clock edge, so a group of settings takes effect as one.

The bank also holds three immediate (single-copy) controls. The first is a read-bank select that decides whether reads return the staging or the live copy. The second is a sticky soft reset that forces every copy back to its default value for as long as it is held. The third is a read-only identification byte. There is a parameterised array of general byte registers at a configurable base address, plus one three-bit power/sync register at a fixed address. The live copies of these drive the block's outputs directly from flops.

Top module: `ctlbank_top`

## Requirements
- R1: A write to a buffered register (general register at `GEN_BASE+i`, or 0x230) changes only its staging copy. `live_ctl_o` and `live_sync_o` keep their values until a transfer takes place.
- R2: Writing a byte with bit 0 = 1 to address 0x232 arms a transfer. On the next clock edge every live copy is loaded from its staging copy. If a buffered write arrives in that same edge, its data is part of the copy. The new live values appear on the outputs after that second edge.
- R3: The transfer bit at 0x232 clears itself. A read of 0x232 returns 0x01 only when the read is issued in the cycle directly after the arming write, and returns 0x00 at all other times. Writing 0 to it arms nothing.
- R4: Bit 0 of address 0x004 selects the read bank. 0 (the reset default) returns staging copies and 1 returns live copies. The other bits of 0x004 read 0.
- R5: Writing bit 2 = 1 at address 0x000 enters soft reset, and the bit stays set until software writes it back to 0. While it is set, all staging copies, all live copies and the read select are forced to their defaults on every edge. Writes to any other address, including 0x232, are ignored. Address 0x000 reads 0x04 while the bit is set and 0x00 once it is cleared.
- R6: Address 0x003 always reads the identification byte 0x61. Writes to it have no effect.
- R7: Address 0x230 holds three writable bits, each a buffered control. Bit 0 is soft sync, bit 1 is the distribution-reference power-down and bit 2 is the sync power-down. Bits 7:3 read 0 and ignore writes. Its default is 0x00. Its live copy drives `live_sync_o[2:0]` in the same bit order.
- R8: Address 0x231 and every unmapped address read 0x00, and writes to them have no effect on any output. Address 0x232 reads 0x00 after reset.
- R9: Read data is registered. `rdata` takes the value the addressed register had before the clock edge at which `rd_en` is sampled, is visible after that edge, and holds its value while `rd_en` is low.
- R10: General register i has the default value `(0x5A xor (0x13*i)) mod 256`, which gives 0x5A, 0x49, 0x7C and 0x63 for i = 0 to 3.
- R11: A synchronous `rst` restores every staging copy, live copy, the soft-reset bit, the read select, the transfer bit and `rdata` (0x00) to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| live_ctl_o | output | N_GEN*8 | Live copies of the general registers, register i in bits [8i+7:8i] |
| live_sync_o | output | 3 | Live copy of the power/sync register bits 2:0 |

## Verification
The bench builds the bank with `N_GEN = 4` and `GEN_BASE = 0x040` under a 10-bit address. Four general registers keep the defaults and the mapped addresses easy to follow by hand. The general window then sits clear of the fixed addresses, so that the random traffic reaches the gaps between them, the top of the address space and the reserved byte 0x231. With this small bank the random phase also lands often enough on the awkward sequences: a buffered write in the edge right after an arming write, reads of 0x232 in the armed cycle, and repeated entry into and exit from soft reset while other writes keep arriving.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Addresses whose positions the behaviour depends on
  localparam int A_CFG  = 'h000;
  localparam int A_ID   = 'h003;
  localparam int A_RSEL = 'h004;
  localparam int A_SYNC = 'h230;
  localparam int A_RSVD = 'h231;
  localparam int A_XFER = 'h232;

  localparam int IDX_W  = 8;
  localparam int SYNC_W = 3;

  typedef enum logic [2:0] {
    K_NONE,
    K_CFG,
    K_ID,
    K_RSEL,
    K_BUF,
    K_XFER
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [IDX_W-1:0] idx;
  } dec_t;

  function automatic logic [7:0] gen_default(int i);
    return 8'h5A ^ 8'(i * 19);
  endfunction
endpackage

// File: rtl/ctlbank_decode.sv
module ctlbank_decode
  import ctlbank_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int N_GEN    = 8,
  parameter int GEN_BASE = 'h010
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int GEN_TOP = GEN_BASE + N_GEN;

  int unsigned a;

  always_comb begin
    a           = 32'(addr_i);
    dec_o.kind  = K_NONE;
    dec_o.idx   = '0;
    if (a == A_CFG) begin
      dec_o.kind = K_CFG;
    end else if (a == A_ID) begin
      dec_o.kind = K_ID;
    end else if (a == A_RSEL) begin
      dec_o.kind = K_RSEL;
    end else if (a == A_XFER) begin
      dec_o.kind = K_XFER;
    end else if (a == A_SYNC) begin
      dec_o.kind = K_BUF;
      dec_o.idx  = IDX_W'(N_GEN);
    end else if (a >= GEN_BASE && a < GEN_TOP) begin
      dec_o.kind = K_BUF;
      dec_o.idx  = IDX_W'(a - GEN_BASE);
    end
  end
endmodule

// File: rtl/ctlbank_slot.sv
module ctlbank_slot #(
  parameter int           W    = 8,
  parameter logic [W-1:0] DFLT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xfer_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] buf_q, act_q, buf_nx;

  always_comb buf_nx = wr_i ? wdata_i : buf_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      buf_q <= DFLT;
      act_q <= DFLT;
    end else begin
      buf_q <= buf_nx;
      if (xfer_i) act_q <= buf_nx;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;

  // R1: live copy moves only on a transfer (or a reset)
  assert_live_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (!xfer_i && !hold_i) |=> $stable(act_o));

  // R2: after a transfer edge, live equals the staging copy
  assert_copy_match_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !hold_i) |=> (act_o == buf_o));

  // R5: soft reset forces both copies to the default
  assert_hold_dflt_R5: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (act_o == DFLT && buf_o == DFLT));
endmodule

// File: rtl/ctlbank_rdmux.sv
module ctlbank_rdmux
  import ctlbank_pkg::*;
#(
  parameter int         NS     = 9,
  parameter logic [7:0] ID_VAL = 8'h61
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  dec_t          dec_i,
  input  logic          srst_i,
  input  logic          sel_i,
  input  logic          xfer_i,
  input  logic [NS*8-1:0] buf_i,
  input  logic [NS*8-1:0] act_i,
  output logic [7:0]    rdata_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [7:0] rd_nx, rd_q;
  int         base;

  always_comb begin
    base  = 32'(dec_i.idx) * 8;
    rd_nx = 8'h00;
    case (dec_i.kind)
      K_CFG:  rd_nx = {5'b0, srst_i, 2'b0};
      K_ID:   rd_nx = ID_VAL;
      K_RSEL: rd_nx = {7'b0, sel_i};
      K_XFER: rd_nx = {7'b0, xfer_i};
      K_BUF:  rd_nx = sel_i ? act_i[base +: 8] : buf_i[base +: 8];
      default: rd_nx = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 8'h00;
    else if (rd_i) rd_q <= rd_nx;
  end

  assign rdata_o = rd_q;

  // R9: read data holds while no read is issued
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
  import ctlbank_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter int         N_GEN    = 8,
  parameter int         GEN_BASE = 'h010,
  parameter logic [7:0] ID_VAL   = 8'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [N_GEN*8-1:0] live_ctl_o,
  output logic [2:0]        live_sync_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = N_GEN + 1;

  dec_t            dec;
  logic            srst_q, sel_q, xfer_q;
  logic            wr_ok;
  logic [NS*8-1:0] buf_all, act_all;

  ctlbank_decode #(
    .ADDR_W  (ADDR_W),
    .N_GEN   (N_GEN),
    .GEN_BASE(GEN_BASE)
  ) u_dec (
    .addr_i(addr),
    .dec_o (dec)
  );

  assign wr_ok = wr_en && !srst_q;

  // Immediate controls
  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else if (wr_en && dec.kind == K_CFG) srst_q <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) sel_q <= 1'b0;
    else if (wr_ok && dec.kind == K_RSEL) sel_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q) xfer_q <= 1'b0;
    else xfer_q <= wr_ok && dec.kind == K_XFER && wdata[0];
  end

  // Buffered registers
  for (genvar i = 0; i < NS; i++) begin : g_slot
    logic wr_s;
    assign wr_s = wr_ok && dec.kind == K_BUF && 32'(dec.idx) == i;

    if (i < N_GEN) begin : g_gen
      logic [7:0] b, a;
      ctlbank_slot #(
        .W   (8),
        .DFLT(gen_default(i))
      ) u_s (
        .clk    (clk),
        .rst    (rst),
        .hold_i (srst_q),
        .wr_i   (wr_s),
        .wdata_i(wdata),
        .xfer_i (xfer_q),
        .buf_o  (b),
        .act_o  (a)
      );
      assign buf_all[i*8 +: 8] = b;
      assign act_all[i*8 +: 8] = a;
    end else begin : g_sync
      logic [SYNC_W-1:0] b, a;
      ctlbank_slot #(
        .W   (SYNC_W),
        .DFLT('0)
      ) u_s (
        .clk    (clk),
        .rst    (rst),
        .hold_i (srst_q),
        .wr_i   (wr_s),
        .wdata_i(wdata[SYNC_W-1:0]),
        .xfer_i (xfer_q),
        .buf_o  (b),
        .act_o  (a)
      );
      assign buf_all[i*8 +: 8] = {{(8-SYNC_W){1'b0}}, b};
      assign act_all[i*8 +: 8] = {{(8-SYNC_W){1'b0}}, a};
    end
  end

  assign live_ctl_o  = act_all[N_GEN*8-1:0];
  assign live_sync_o = act_all[N_GEN*8 +: SYNC_W];

  ctlbank_rdmux #(
    .NS    (NS),
    .ID_VAL(ID_VAL)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (rd_en),
    .dec_i  (dec),
    .srst_i (srst_q),
    .sel_i  (sel_q),
    .xfer_i (xfer_q),
    .buf_i  (buf_all),
    .act_i  (act_all),
    .rdata_o(rdata)
  );

  // R3: the transfer bit never survives an edge without a fresh arming write
  assert_xfer_selfclr_R3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(A_XFER)) |=> !xfer_q);

  // R5: soft reset is sticky until 0x000 is written
  assert_srst_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (srst_q && !(wr_en && addr == ADDR_W'(A_CFG))) |=> srst_q);

  // R4: soft reset returns the read select to staging
  assert_rsel_dflt_R4: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> !sel_q);

  // R6: identification byte
  assert_id_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_ID)) |=> (rdata == ID_VAL));

  // R8: reserved byte reads zero
  assert_rsvd_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_RSVD)) |=> (rdata == 8'h00));
endmodule

// File: tb/sim_ctlbank_top.sv
module sim_ctlbank_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 10;
  localparam int NG = 4;
  localparam int GB = 'h040;
  localparam int NS = NG + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NG*8-1:0] live_ctl_o;
  logic [2:0]    live_sync_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  ctlbank_top #(
    .ADDR_W(AW), .N_GEN(NG), .GEN_BASE(GB), .ID_VAL(8'h61)
  ) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_ctl_o(live_ctl_o),
    .live_sync_o(live_sync_o)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] mb[NS];
  logic [7:0] ma[NS];
  logic       msr, msel, mxf;
  logic [7:0] mrd;

  function automatic logic [7:0] dflt(int i);
    if (i < NG) return 8'h5A ^ 8'(i * 19);
    return 8'h00;
  endfunction

  function automatic int slot_of(int a);
    if (a == 'h230) return NG;
    if (a >= GB && a < GB + NG) return a - GB;
    return -1;
  endfunction

  function automatic logic [7:0] mread(int a);
    int s;
    s = slot_of(a);
    if (a == 0) return {5'b0, msr, 2'b0};
    if (a == 3) return 8'h61;
    if (a == 4) return {7'b0, msel};
    if (a == 'h232) return {7'b0, mxf};
    if (s >= 0) return msel ? ma[s] : mb[s];
    return 8'h00;
  endfunction

  always @(posedge clk) begin : model
    int   s;
    int   a;
    logic nxf;
    a = int'(addr);
    s = slot_of(a);
    if (rst) begin
      for (int i = 0; i < NS; i++) begin mb[i] = dflt(i); ma[i] = dflt(i); end
      msr = 0; msel = 0; mxf = 0; mrd = 8'h00;
    end else begin
      if (rd_en) mrd = mread(a);
      if (msr) begin
        for (int i = 0; i < NS; i++) begin mb[i] = dflt(i); ma[i] = dflt(i); end
        msel = 0; mxf = 0;
        if (wr_en && a == 0) msr = wdata[2];
      end else begin
        nxf = 1'b0;
        if (wr_en) begin
          if (a == 0) msr = wdata[2];
          else if (a == 4) msel = wdata[0];
          else if (a == 'h232) nxf = wdata[0];
          else if (s >= 0) mb[s] = (s == NG) ? {5'b0, wdata[2:0]} : wdata;
        end
        if (mxf) for (int i = 0; i < NS; i++) ma[i] = mb[i];
        mxf = nxf;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R9 rdata vs model", rdata, mrd);
    for (int i = 0; i < NG; i++) chk("R1 live_ctl vs model", live_ctl_o[i*8 +: 8], ma[i]);
    chk("R7 live_sync vs model", {5'b0, live_sync_o}, ma[NG]);
  endtask

  task automatic cyc(input logic w, input logic r, input int a, input logic [7:0] d);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    compare_all();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00);
    chk(tag, rdata, exp);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 0, 8'h00);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    @(negedge clk);
    do_reset();

    // R11 / R10 reset state
    chk("R11 live_ctl[0] reset", live_ctl_o[7:0], 8'h5A);
    chk("R10 live_ctl[1] default", live_ctl_o[15:8], 8'h49);
    chk("R10 live_ctl[2] default", live_ctl_o[23:16], 8'h7C);
    chk("R10 live_ctl[3] default", live_ctl_o[31:24], 8'h63);
    chk("R11 live_sync reset", {5'b0, live_sync_o}, 8'h00);
    chk("R11 rdata reset", rdata, 8'h00);
    rd('h232, 8'h00, "R8 transfer reads 0 after reset");
    rd(4, 8'h00, "R4 read select default");

    // R1 staging write invisible
    wr(GB + 0, 8'hC3);
    idle(); idle();
    chk("R1 live unchanged after staging write", live_ctl_o[7:0], 8'h5A);
    rd(GB + 0, 8'hC3, "R4 sel=0 reads staging");
    wr(4, 8'h01);
    rd(GB + 0, 8'h5A, "R4 sel=1 reads live");
    rd(4, 8'h01, "R4 select readback");
    wr(4, 8'h00);

    // R9 read before write in same edge
    cyc(1'b1, 1'b1, GB + 2, 8'h99);
    chk("R9 read returns pre-edge value", rdata, 8'h7C);

    // R2 transfer with merged write, R3 self clear
    wr('h232, 8'h01);
    wr(GB + 1, 8'hA5);
    chk("R2 live[0] copied", live_ctl_o[7:0], 8'hC3);
    chk("R2 merged write included", live_ctl_o[15:8], 8'hA5);
    chk("R2 live[2] copied", live_ctl_o[23:16], 8'h99);
    wr('h232, 8'h01);
    rd('h232, 8'h01, "R3 armed cycle reads 1");
    rd('h232, 8'h00, "R3 bit cleared");
    wr(GB + 3, 8'h3C);
    wr('h232, 8'h00);
    idle();
    chk("R3 writing 0 arms nothing", live_ctl_o[31:24], 8'h63);

    // R6 identification
    wr(3, 8'hFF);
    rd(3, 8'h61, "R6 id after write");

    // R8 reserved and unmapped
    wr('h231, 8'hFF);
    rd('h231, 8'h00, "R8 reserved reads 0");
    wr('h100, 8'hFF);
    rd('h100, 8'h00, "R8 unmapped reads 0");
    rd('h3FF, 8'h00, "R8 top address reads 0");
    chk("R8 unmapped write no effect", live_ctl_o[7:0], 8'hC3);

    // R7 power/sync register
    wr('h230, 8'hFF);
    rd('h230, 8'h07, "R7 reserved bits read 0");
    chk("R7 live_sync before transfer", {5'b0, live_sync_o}, 8'h00);
    wr('h232, 8'h01);
    idle();
    chk("R7 live_sync after transfer", {5'b0, live_sync_o}, 8'h07);
    wr('h230, 8'h02);
    wr('h232, 8'h01);
    idle();
    chk("R7 bit1 only", {5'b0, live_sync_o}, 8'h02);

    // R5 soft reset
    wr(4, 8'h01);
    wr(0, 8'h04);
    idle();
    chk("R5 live forced to default", live_ctl_o[7:0], 8'h5A);
    chk("R5 sync forced to default", {5'b0, live_sync_o}, 8'h00);
    wr(GB + 0, 8'h22);
    wr('h232, 8'h01);
    wr(4, 8'h01);
    idle();
    chk("R5 writes ignored in soft reset", live_ctl_o[7:0], 8'h5A);
    rd(0, 8'h04, "R5 reset bit sticky");
    wr(0, 8'h00);
    rd(0, 8'h00, "R5 reset bit cleared");
    rd(4, 8'h00, "R5 select back to default");
    rd(GB + 0, 8'h5A, "R5 staging at default");
    wr(GB + 0, 8'h77);
    wr('h232, 8'h01);
    idle();
    chk("R5 writable after clear", live_ctl_o[7:0], 8'h77);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic [7:0] d;
      d = 8'($urandom);
      case ($urandom_range(0, 11))
        0: begin a = 0; d[2] = ($urandom_range(0, 3) == 0); end
        1: a = 3;
        2: a = 4;
        3: a = 'h230;
        4: a = 'h231;
        5, 6: a = 'h232;
        7: a = $urandom_range(0, AW'('1));
        default: a = GB + $urandom_range(0, NG - 1);
      endcase
      cyc(1'($urandom), 1'($urandom), a, d);
    end

    // R11 synchronous reset mid-run
    wr(GB + 2, 8'h11);
    wr('h232, 8'h01);
    idle();
    do_reset();
    chk("R11 live[2] after rst", live_ctl_o[23:16], 8'h7C);
    chk("R11 sync after rst", {5'b0, live_sync_o}, 8'h00);
    rd(0, 8'h00, "R11 soft reset bit cleared");
    rd(GB + 2, 8'h7C, "R11 staging restored");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule